// File: doc/BRIEF.md
# Two-Ratio Synchronous Clock Divider

This block divides its clock by one of two adjacent integers and is meant to sit in front of the programmable counters of a frequency-synthesis loop. The counters ask for the smaller or the larger ratio on each output period. A build-time parameter picks the pair. `MODE = 0` gives 5 or 6 and `MODE = 1` gives 8 or 9. Five ratio-select inputs are ORed together. If any of them is high, the next period uses the smaller ratio. If all five are low, it uses the larger ratio.

The core is a three-stage phase machine with six named states, written as bits A B C: `PH_111`, `PH_011`, `PH_001`, `PH_000`, `PH_100` and `PH_110`. The transitions are:
- `PH_111` goes to `PH_011`, and `PH_011` goes to `PH_001`.
- `PH_001` is the decision state. It goes to `PH_000` (long path) or to `PH_100` (skip).
- `PH_000` goes to `PH_100`.
- `PH_100` goes to `PH_110` in the 5/6 build and straight back to `PH_111` in the 8/9 build. That return to `PH_111` is called the wrap.
- `PH_110` goes to `PH_111`.
- Any other code goes to `PH_111`.

In the 5/6 build, bit C of the phase machine is the output. In the 8/9 build, a toggle stage flips on every wrap and drives the output. The long path through `PH_000` is allowed only while the toggle stage is high. The output is given in true and complement form.

Top module: `dual_ratio_prescaler`

## Requirements
- R1: While `rst` is high at a rising edge, the phase machine and toggle stage load all ones. After that edge, `div_q` is 1 and `div_qn` is 0.
- R2: In the 5/6 build with all five selects low, `div_q` is high for 3 clocks and low for 3, so its rising edges are 6 clocks apart.
- R3: In the 5/6 build with any one or more selects high, `div_q` is high for 3 clocks and low for 2, a period of 5.
- R4: In the 8/9 build with all selects low, `div_q` is high for 5 clocks and low for 4, a period of 9.
- R5: In the 8/9 build with any one or more selects high, `div_q` is high for 4 clocks and low for 4, a period of 8.
- R6: `div_qn` is always the inverse of `div_q`.
- R7: The selects are sampled only at the rising edge that ends the third high clock of `div_q`, which is the `PH_001` state. A select pulse in any other cycle has no effect on the current period. In the 5/6 build, a sampled request shortens the following low phase. In the 8/9 build, it shortens the current high phase.
- R8: After reset is released with all selects low, `div_q` first reads low after the 3rd rising edge in the 5/6 build and after the 5th rising edge in the 8/9 build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 5 | Ratio selects; any bit high requests the smaller ratio |
| div_q | output | 1 | Divided output, true form |
| div_qn | output | 1 | Divided output, complement form |

## Verification
The bench targets the decision point. It pulses a select in the first high cycle and then in the third, and expects only the second pulse to change the period. A design that sampled the selects in every cycle, or in the wrong state, would shorten the wrong phase or shorten it twice.

Single-bit and mixed select patterns check that the OR reduction is complete. A design that ignored one of the five inputs would keep dividing by the larger ratio for that pattern.

The 8/9 checks measure the high and low runs separately. A skip placed in the low half, or a toggle stage that flipped on the wrong edge, would still give a period of 9 but with the runs swapped.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
    localparam int SEL_W = 5;

    typedef enum logic [2:0] {
        PH_111 = 3'b111,
        PH_011 = 3'b011,
        PH_001 = 3'b001,
        PH_000 = 3'b000,
        PH_100 = 3'b100,
        PH_110 = 3'b110
    } phase_t;
endpackage

// File: rtl/dmp_ratio_select.sv
module dmp_ratio_select #(
    parameter int N = 5
) (
    input  logic [N-1:0] sel_i,
    output logic         short_o
);
    // Any asserted select requests the smaller ratio.
    always_comb begin
        short_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            short_o = short_o | sel_i[i];
        end
    end
endmodule

// File: rtl/dmp_phase_seq.sv
module dmp_phase_seq
    import dmp_pkg::*;
#(
    parameter int MODE = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   short_i,
    input  logic   long_ok_i,
    output phase_t state_o,
    output logic   wrap_o
);
    localparam bit NINE = (MODE == 1);

    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_111;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_111:  state_d = PH_011;
            PH_011:  state_d = PH_001;
            PH_001:  state_d = (long_ok_i && !short_i) ? PH_000 : PH_100;
            PH_000:  state_d = PH_100;
            PH_100:  state_d = NINE ? PH_111 : PH_110;
            PH_110:  state_d = PH_111;
            default: state_d = PH_111;
        endcase
    end

    always_comb begin
        state_o = state_q;
        wrap_o  = NINE && (state_q == PH_100);
    end

    // R2
    ph_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_111) |=> (state_q == PH_011));

    // R7
    ph_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_001 && short_i) |=> (state_q == PH_100));

    // R4
    ph_close_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_100) |=> (state_q == (NINE ? PH_111 : PH_110)));
endmodule

// File: rtl/dmp_toggle.sv
module dmp_toggle (
    input  logic clk,
    input  logic rst,
    input  logic flip_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)         q_o <= 1'b1;
        else if (flip_i) q_o <= ~q_o;
    end

    // R5
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flip_i |=> $stable(q_o));
endmodule

// File: rtl/dual_ratio_prescaler.sv
module dual_ratio_prescaler
    import dmp_pkg::*;
#(
    parameter int MODE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             div_q,
    output logic             div_qn
);
    logic   short_req;
    logic   long_ok;
    logic   wrap;
    phase_t phase;

    dmp_ratio_select #(.N(SEL_W)) u_sel (
        .sel_i   (ratio_sel),
        .short_o (short_req)
    );

    dmp_phase_seq #(.MODE(MODE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .short_i   (short_req),
        .long_ok_i (long_ok),
        .state_o   (phase),
        .wrap_o    (wrap)
    );

    generate
        if (MODE == 1) begin : g_nine
            logic tq;
            dmp_toggle u_tog (
                .clk    (clk),
                .rst    (rst),
                .flip_i (wrap),
                .q_o    (tq)
            );
            assign long_ok = tq;
            assign div_q   = tq;
        end else begin : g_six
            assign long_ok = 1'b1;
            assign div_q   = phase[0];
        end
    endgenerate

    assign div_qn = ~div_q;

    // R1
    rst_ones_chk: assert property (@(posedge clk)
        rst |=> (div_q && !div_qn));

    // R6
    compl_chk: assert property (@(posedge clk) disable iff (rst)
        (div_q != div_qn));
endmodule

// File: tb/dual_ratio_prescaler_test.sv
module dual_ratio_prescaler_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sel = 5'b0;
    logic       q6, qn6, q9, qn9;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_ratio_prescaler #(.MODE(1)) uut (
        .clk(clk), .rst(rst), .ratio_sel(sel), .div_q(q9), .div_qn(qn9));
    dual_ratio_prescaler #(.MODE(0)) uut6 (
        .clk(clk), .rst(rst), .ratio_sel(sel), .div_q(q6), .div_qn(qn6));

    // run-length trackers, sampled at falling edges
    logic p6 = 1'b1, p9 = 1'b1;
    int run6 = 0, run9 = 0, hi6 = 0, lo6 = 0, hi9 = 0, lo9 = 0;
    always @(negedge clk) begin
        if (q6 != p6) begin
            if (p6) hi6 = run6; else lo6 = run6;
            run6 = 1;
        end else run6 = run6 + 1;
        p6 = q6;
        if (q9 != p9) begin
            if (p9) hi9 = run9; else lo9 = run9;
            run9 = 1;
        end else run9 = run9 + 1;
        p9 = q9;
    end

    // R6 continuous complement check at every falling edge
    always @(negedge clk) begin
        #1;
        if (!done && (qn6 !== ~q6 || qn9 !== ~q9)) begin
            errors++;
            $display("FAIL R6 complement: q6=%b qn6=%b q9=%b qn9=%b expected inverse", q6, qn6, q9, qn9);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // {sel, hi6, lo6, hi9, lo9}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {5'b00000, 4'd3, 4'd3, 4'd5, 4'd4},
        {5'b00001, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b00010, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b00100, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b01000, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b10000, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b11111, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b00000, 4'd3, 4'd3, 4'd5, 4'd4},
        {5'b10101, 4'd3, 4'd2, 4'd4, 4'd4},
        {5'b01100, 4'd3, 4'd2, 4'd4, 4'd4}
    };

    initial begin
        // R1 reset state
        repeat (3) step();
        chk("R1 q6 in reset", int'(q6), 1);
        chk("R1 qn6 in reset", int'(qn6), 0);
        chk("R1 q9 in reset", int'(q9), 1);
        chk("R1 qn9 in reset", int'(qn9), 0);

        // R8 first fall after release
        rst = 1'b0;
        begin
            int k6 = 0, k9 = 0;
            for (int c = 1; c <= 12; c++) begin
                step();
                if (k6 == 0 && !q6) k6 = c;
                if (k9 == 0 && !q9) k9 = c;
            end
            chk("R8 first fall 5/6", k6, 3);
            chk("R8 first fall 8/9", k9, 5);
        end

        // R2..R5 table walk
        for (int v = 0; v < NV; v++) begin
            sel = VEC[v][20:16];
            repeat (40) step();
            chk((VEC[v][20:16] == 0) ? "R2 high 5/6" : "R3 high 5/6", hi6, int'(VEC[v][15:12]));
            chk((VEC[v][20:16] == 0) ? "R2 low 5/6"  : "R3 low 5/6",  lo6, int'(VEC[v][11:8]));
            chk((VEC[v][20:16] == 0) ? "R4 high 8/9" : "R5 high 8/9", hi9, int'(VEC[v][7:4]));
            chk((VEC[v][20:16] == 0) ? "R4 low 8/9"  : "R5 low 8/9",  lo9, int'(VEC[v][3:0]));
        end

        // R7 pulse in the first high cycle: ignored (5/6)
        sel = 5'b0;
        repeat (20) step();
        while (q6) step();
        while (!q6) step();
        sel = 5'b00001; step(); sel = 5'b0;
        while (q6) step();
        while (!q6) step();
        chk("R7 early pulse ignored, low 5/6", lo6, 3);
        // R7 pulse in the third high cycle: taken (5/6)
        while (q6) step();
        while (!q6) step();
        step(); step();
        sel = 5'b00100; step(); sel = 5'b0;
        while (q6) step();
        while (!q6) step();
        chk("R7 decision pulse taken, low 5/6", lo6, 2);

        // R7 for 8/9
        while (q9) step();
        while (!q9) step();
        sel = 5'b10000; step(); sel = 5'b0;
        while (q9) step();
        chk("R7 early pulse ignored, high 8/9", hi9, 5);
        while (!q9) step();
        step(); step();
        sel = 5'b01000; step(); sel = 5'b0;
        while (q9) step();
        chk("R7 decision pulse taken, high 8/9", hi9, 4);

        // R1 reset mid-run
        step(); step();
        rst = 1'b1; step();
        chk("R1 q6 after mid-run reset", int'(q6), 1);
        chk("R1 q9 after mid-run reset", int'(q9), 1);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule